// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the host side of a two-bank SDRAM and owns the command pins from reset. It first runs the bring-up sequence. Clock enable and both byte masks are held high through a programmable settling wait. A precharge of all banks follows, then a programmable number of auto-refresh commands, then a mode-register load that writes a configured op-code. Once the mode-load recovery time has passed, it raises `ready`.

After that it keeps a free-running refresh timer. Every `REF_INTERVAL` cycles the timer raises a refresh request. This interval is normally set to the refresh period divided by 1024. When the sequencer services a request, it first checks the open-bank flags that the user side reports. If any bank is open, it issues a precharge-all and waits the precharge time before it issues the auto-refresh. After the refresh it drives only deselects for the refresh cycle time.

A user request port shares the command bus. The grant is given only when the device is ready and no refresh is pending. A user that already holds the grant keeps it until it drops its request, and a refresh that comes due meanwhile waits. While the user holds the grant, the sequencer drives deselect so that an outside multiplexer can pass the user's commands.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: While reset is asserted: `sd_cke` is low, both `sd_dqm` bits are high, the command pins {cs_n,ras_n,cas_n,we_n} read 4'b1111 (deselect), and `ready` and `user_grant` are low.
- R2: From the first clock after reset release, `sd_cke` is high. During the first `WAIT_CYC` cycles (cycle 0 is the cycle in which reset is released), only deselects are issued and `sd_dqm` stays all ones for as long as `ready` is low.
- R3: In cycle `WAIT_CYC` a precharge-all is issued: pins 4'b0010 with `sd_addr[AP_BIT]` high. The next command follows exactly `T_RP` cycles later.
- R4: During bring-up, `INIT_REFS` auto-refresh commands (pins 4'b0001) are issued `T_RC` cycles apart, with only deselects between them.
- R5: `T_RC` cycles after the last bring-up refresh, a mode load (pins 4'b0000) is issued with `sd_addr` equal to `MODE_OP`. `ready` rises `T_RSC` cycles after it, stays high, and `sd_dqm` is low from then on.
- R6: If no user holds the bus and all banks are closed, each refresh request leads to an auto-refresh. The first one comes `REF_INTERVAL+1` cycles after `ready` rises, and later ones follow every `REF_INTERVAL` cycles.
- R7: If any bit of `user_bank_open` is high when a refresh is serviced, a precharge-all (4'b0010, `sd_addr[AP_BIT]` high) is issued first, and the auto-refresh follows `T_RP` cycles later. This holds for every non-zero pattern of open banks.
- R8: For `T_RC-1` cycles after each auto-refresh, only deselects are driven and no grant is given.
- R9: `user_grant` is never high before `ready`. A new grant is not given while a refresh request is pending.
- R10: A grant rises one cycle after a request is seen in the idle state. It stays high until one cycle after the request drops, even if a refresh comes due meanwhile. The refresh then starts on the cycle after the grant falls.
- R11: While `user_grant` is high, the sequencer drives deselect (4'b1111).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| user_req | input | 1 | User asks for, and keeps holding, the command bus |
| user_bank_open | input | NUM_BANKS | Per-bank open flags reported by the user side |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address (precharge-all bit, mode op-code) |
| sd_dqm | output | DQM_W | Byte masks, high during bring-up |
| sd_cke | output | 1 | Clock enable |
| user_grant | output | 1 | User owns the command bus |
| ready | output | 1 | Bring-up complete |

## Verification
The assertions assume that `user_bank_open` truthfully reflects the banks the user left open. They also assume that a user holding the grant drops `user_req` within a refresh interval, so that a pending refresh is never overtaken by the next tick. The stimulus changes the open-bank flags only around refresh points, while nobody holds the bus. It keeps each user hold shorter than `REF_INTERVAL`, and in one case it places a request so that it arrives in the same cycle a refresh is pending. That case exercises the blocking rule.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [1:0] {
    CMD_DESEL,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } seq_cmd_e;

  typedef enum logic [3:0] {
    S_PWR_WAIT,
    S_INIT_PRE,
    S_INIT_TRP,
    S_INIT_REF,
    S_INIT_TRC,
    S_MRS,
    S_TRSC,
    S_IDLE,
    S_USER,
    S_RF_PRE,
    S_RF_TRP,
    S_RF_REF,
    S_RF_TRC
  } seq_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  function automatic logic [3:0] cmd_pins(seq_cmd_e c);
    case (c)
      CMD_PRE: return 4'b0010;
      CMD_REF: return 4'b0001;
      CMD_MRS: return 4'b0000;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // cycle index at which ready is first high after reset release
  function automatic int unsigned init_span(int unsigned wait_c, int unsigned trp,
                                            int unsigned trc, int unsigned nref,
                                            int unsigned trsc);
    return wait_c + trp + nref * trc + trsc;
  endfunction

endpackage

// File: rtl/seq_delay_timer.sv
module seq_delay_timer #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= CNT_W'(RST_VAL);
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/seq_refresh_timer.sv
module seq_refresh_timer #(
  parameter int unsigned INTERVAL = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic pending
);
  localparam int unsigned TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0] tick_q;
  logic          wrap;

  assign wrap = run && (tick_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q  <= '0;
      pending <= 1'b0;
    end else begin
      if (run) tick_q <= wrap ? '0 : tick_q + 1'b1;
      if (wrap)       pending <= 1'b1;
      else if (clear) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/seq_cmd_encoder.sv
module seq_cmd_encoder
  import sdram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 9,
  parameter int unsigned AP_BIT  = 8,
  parameter logic [ADDR_W-1:0] MODE_OP = '0
) (
  input  seq_cmd_e          cmd,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    {cs_n, ras_n, cas_n, we_n} = cmd_pins(cmd);
    addr = '0;
    if (cmd == CMD_PRE)      addr[AP_BIT] = 1'b1;
    else if (cmd == CMD_MRS) addr = MODE_OP;
  end
endmodule

// File: rtl/sdram_init_refresh_seq.sv
module sdram_init_refresh_seq
  import sdram_seq_pkg::*;
#(
  parameter int unsigned NUM_BANKS    = 2,
  parameter int unsigned ADDR_W       = 9,
  parameter int unsigned AP_BIT       = 8,
  parameter int unsigned DQM_W        = 2,
  parameter int unsigned WAIT_CYC     = 200,
  parameter int unsigned T_RP         = 3,
  parameter int unsigned T_RC         = 9,
  parameter int unsigned T_RSC        = 2,
  parameter int unsigned INIT_REFS    = 2,
  parameter int unsigned REF_INTERVAL = 780,
  parameter logic [ADDR_W-1:0] MODE_OP = 9'h032
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 user_req,
  input  logic [NUM_BANKS-1:0] user_bank_open,
  output logic                 sd_cs_n,
  output logic                 sd_ras_n,
  output logic                 sd_cas_n,
  output logic                 sd_we_n,
  output logic [ADDR_W-1:0]    sd_addr,
  output logic [DQM_W-1:0]     sd_dqm,
  output logic                 sd_cke,
  output logic                 user_grant,
  output logic                 ready
);
  localparam int unsigned MAXV  = max2(max2(WAIT_CYC, T_RP), max2(T_RC, T_RSC));
  localparam int unsigned CNT_W = $clog2(MAXV + 1);
  localparam int unsigned NR_W  = $clog2(INIT_REFS + 1);

  seq_state_e state_q, state_d;
  seq_cmd_e   cmd;
  logic [NR_W-1:0]  nref_q;
  logic [CNT_W-1:0] load_val;
  logic             dly_zero;
  logic             ready_q, cke_q;

  // named internal events
  logic ref_pending;
  logic ref_issue;
  logic pre_issue;
  logic timer_load;
  logic nref_done;
  logic any_open;

  assign ref_issue  = (cmd == CMD_REF);
  assign pre_issue  = (cmd == CMD_PRE);
  assign timer_load = (cmd != CMD_DESEL);
  assign nref_done  = (nref_q == NR_W'(INIT_REFS));
  assign any_open   = |user_bank_open;

  always_comb begin
    case (state_q)
      S_INIT_PRE, S_RF_PRE: cmd = CMD_PRE;
      S_INIT_REF, S_RF_REF: cmd = CMD_REF;
      S_MRS:                cmd = CMD_MRS;
      default:              cmd = CMD_DESEL;
    endcase
  end

  always_comb begin
    case (state_q)
      S_INIT_PRE, S_RF_PRE: load_val = CNT_W'(T_RP - 2);
      S_INIT_REF, S_RF_REF: load_val = CNT_W'(T_RC - 2);
      S_MRS:                load_val = CNT_W'(T_RSC - 2);
      default:              load_val = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_PWR_WAIT: if (dly_zero) state_d = S_INIT_PRE;
      S_INIT_PRE: state_d = S_INIT_TRP;
      S_INIT_TRP: if (dly_zero) state_d = S_INIT_REF;
      S_INIT_REF: state_d = S_INIT_TRC;
      S_INIT_TRC: if (dly_zero) state_d = nref_done ? S_MRS : S_INIT_REF;
      S_MRS:      state_d = S_TRSC;
      S_TRSC:     if (dly_zero) state_d = S_IDLE;
      S_IDLE: begin
        if (ref_pending)   state_d = any_open ? S_RF_PRE : S_RF_REF;
        else if (user_req) state_d = S_USER;
      end
      S_USER:     if (!user_req) state_d = S_IDLE;
      S_RF_PRE:   state_d = S_RF_TRP;
      S_RF_TRP:   if (dly_zero) state_d = S_RF_REF;
      S_RF_REF:   state_d = S_RF_TRC;
      S_RF_TRC:   if (dly_zero) state_d = S_IDLE;
      default:    state_d = S_PWR_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_PWR_WAIT;
      nref_q  <= '0;
      ready_q <= 1'b0;
      cke_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cke_q   <= 1'b1;
      if (state_q == S_INIT_REF) nref_q <= nref_q + 1'b1;
      if (state_q == S_TRSC && dly_zero) ready_q <= 1'b1;
    end
  end

  seq_delay_timer #(.CNT_W(CNT_W), .RST_VAL(WAIT_CYC - 1)) u_dly (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .load_val(load_val), .zero(dly_zero)
  );

  seq_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_rtmr (
    .clk(clk), .rst_n(rst_n), .run(ready_q),
    .clear(ref_issue && ready_q), .pending(ref_pending)
  );

  seq_cmd_encoder #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .MODE_OP(MODE_OP)) u_enc (
    .cmd(cmd), .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n),
    .we_n(sd_we_n), .addr(sd_addr)
  );

  assign sd_cke     = cke_q;
  assign sd_dqm     = ready_q ? '0 : '1;
  assign ready      = ready_q;
  assign user_grant = (state_q == S_USER);
endmodule

// File: rtl/sdram_seq_checker.sv
module sdram_seq_checker #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned AP_BIT = 8,
  parameter int unsigned DQM_W  = 2,
  parameter int unsigned T_RC   = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DQM_W-1:0]  dqm,
  input logic              user_grant,
  input logic              ready,
  input logic              ref_pending,
  input logic              ref_issue,
  input logic              pre_issue
);
  localparam int unsigned SW = $clog2(T_RC + 1);
  logic [SW-1:0] since_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          since_ref <= '0;
    else if (ref_issue)                  since_ref <= SW'(1);
    else if (since_ref == SW'(T_RC - 1)) since_ref <= '0;
    else if (since_ref != '0)            since_ref <= since_ref + 1'b1;
  end

  // R11
  granted_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    user_grant |-> cs_n);
  // R9
  grant_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    user_grant |-> ready);
  // R9
  grant_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(user_grant) |-> !$past(ref_pending));
  // R7
  pre_all_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_issue |-> (addr[AP_BIT] && !cs_n));
  // R8
  trc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_ref != '0) |-> (cs_n && !user_grant));
  // R5
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  // R2
  dqm_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (&dqm));
  // R6
  pending_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_issue && ready) |=> !ref_pending);
endmodule

bind sdram_init_refresh_seq sdram_seq_checker #(
  .ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .DQM_W(DQM_W), .T_RC(T_RC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(sd_cs_n), .addr(sd_addr), .dqm(sd_dqm),
  .user_grant(user_grant), .ready(ready), .ref_pending(ref_pending),
  .ref_issue(ref_issue), .pre_issue(pre_issue)
);

// File: tb/tb_sdram_init_refresh_seq.sv
module tb_sdram_init_refresh_seq;
  localparam int unsigned WAIT_C = 8, TRP = 3, TRC = 4, TRSC = 2, NREF = 2, RIV = 40;
  localparam logic [8:0]  MOP = 9'h032;
  localparam logic [3:0]  P_DES = 4'b1111, P_PRE = 4'b0010, P_REF = 4'b0001, P_MRS = 4'b0000;
  localparam int          RDY = WAIT_C + TRP + NREF * TRC + TRSC;  // 21
  localparam int          LAST_K = 300;

  logic clk = 1'b0, rst_n = 1'b0, user_req = 1'b0;
  logic [1:0] bank_open = 2'b00;
  logic cs_n, ras_n, cas_n, we_n, cke, grant, ready;
  logic [8:0] addr;
  logic [1:0] dqm;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sdram_init_refresh_seq #(
    .WAIT_CYC(WAIT_C), .T_RP(TRP), .T_RC(TRC), .T_RSC(TRSC),
    .INIT_REFS(NREF), .REF_INTERVAL(RIV), .MODE_OP(MOP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .user_req(user_req), .user_bank_open(bank_open),
    .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
    .sd_addr(addr), .sd_dqm(dqm), .sd_cke(cke), .user_grant(grant), .ready(ready)
  );

  task automatic check(string req, int k, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual %h expected %h", req, k, act, exp);
    end
  endtask

  // refresh REF cycles after ready: epoch j pending at RDY+RIV+40j
  function automatic bit is_rf_ref(int k);
    if (k == RDY + RIV + 1) return 1;
    for (int j = 1; j < 4; j++) if (k == RDY + RIV + 1 + RIV * j + TRP) return 1;
    return (k == 232) || (k == 262);
  endfunction

  function automatic bit is_rf_pre(int k);
    for (int j = 1; j < 4; j++) if (k == RDY + RIV + 1 + RIV * j) return 1;
    return 0;
  endfunction

  function automatic logic [3:0] exp_cmd(int k);
    if (k == WAIT_C) return P_PRE;
    for (int i = 0; i < NREF; i++) if (k == WAIT_C + TRP + i * TRC) return P_REF;
    if (k == WAIT_C + TRP + NREF * TRC) return P_MRS;
    if (is_rf_pre(k)) return P_PRE;
    if (is_rf_ref(k)) return P_REF;
    return P_DES;
  endfunction

  function automatic bit after_ref(int k);
    for (int d = 1; d < TRC; d++) if (is_rf_ref(k - d)) return 1;
    return 0;
  endfunction

  function automatic string cmd_tag(int k);
    if (k < WAIT_C) return "R2";
    if (k == WAIT_C) return "R3";
    if (k < WAIT_C + TRP + NREF * TRC) return "R4";
    if (k < RDY) return "R5";
    if (is_rf_pre(k) || (k > 100 && k < 190 && is_rf_ref(k))) return "R7";
    if (after_ref(k)) return "R8";
    return "R6";
  endfunction

  function automatic bit exp_grant(int k);
    return (k >= 22 && k <= 25) || (k >= 200 && k <= 230) || (k >= 267 && k <= 275);
  endfunction

  function automatic string grant_tag(int k);
    if (k < RDY || (k >= 262 && k <= 266)) return "R9";
    return "R10";
  endfunction

  function automatic logic drive_req(int k);
    return (k >= 5 && k <= 24) || (k >= 199 && k <= 229) || (k >= 261 && k <= 274);
  endfunction

  function automatic logic [1:0] drive_open(int k);
    for (int j = 1; j < 4; j++) if (k >= 40 * j + 45 && k <= 40 * j + 70) return 2'(j);
    return 2'b00;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", -1, {9'd0, cke, dqm, cs_n, ras_n, cas_n, we_n},
          {9'd0, 1'b0, 2'b11, P_DES});
    check("R1", -1, {14'd0, ready, grant}, 16'd0);
    rst_n = 1'b1;
    for (int k = 0; k <= LAST_K; k++) begin
      logic [3:0] e;
      e = exp_cmd(k);
      check(cmd_tag(k), k, {12'd0, cs_n, ras_n, cas_n, we_n}, {12'd0, e});
      if (e == P_PRE) check(k > RDY ? "R7" : "R3", k, {15'd0, addr[8]}, 16'd1);
      if (e == P_MRS) check("R5", k, {7'd0, addr}, {7'd0, MOP});
      check(grant_tag(k), k, {15'd0, grant}, {15'd0, exp_grant(k)});
      if (grant) check("R11", k, {15'd0, cs_n}, 16'd1);
      check("R5", k, {15'd0, ready}, {15'd0, (k >= RDY)});
      check(k < RDY ? "R2" : "R5", k, {14'd0, dqm}, (k < RDY) ? 16'd3 : 16'd0);
      if (k >= 1) check("R2", k, {15'd0, cke}, 16'd1);
      user_req  = drive_req(k);
      bank_open = drive_open(k);
      @(negedge clk);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule